// File: doc/BRIEF.md
# SPI Controller Interrupt Status and Mask Unit

This unit holds the interrupt registers of an SPI master controller. The transfer engine drives one condition line per interrupt source. Edge-type sources are caught in sticky status bits that software clears by writing ones. Level-type sources, such as receive data waiting or a full transmit queue, show their live value in the status register. Software can therefore poll the receive-data bit while it drains the receive queue.

The enable mask is never written directly. Writing ones to the set register turns mask bits on, and writing ones to the clear register turns them off. A read-only view returns the current mask. A single registered, level-sensitive interrupt line goes high while any status bit is set together with its mask bit. Software reaches the unit through a plain register port: address, write strobe, write data and combinational read data.

Top module: `spi_irq_unit`

## Requirements
- R1: After reset the status register, the mask register and `irq_o` are all zero.
- R2: A write to offset 0x08 sets each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged. The mask is read back at offset 0x10.
- R3: A write to offset 0x0C clears each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R4: Reads of offsets 0x08 and 0x0C, and of any offset other than 0x04 and 0x10, return zero.
- R5: Sticky status bits (bits 0, 1, 2, 5 and 6; bit 1 is mode fault and bit 2 is transmit below threshold) set one cycle after their condition input is high. They stay set until a write to offset 0x04 has a 1 in that bit position. Writing 0 to a bit leaves it unchanged.
- R6: Live status bits 3 (transmit full) and 4 (receive not empty) equal their condition input as registered one cycle earlier. Writes to offset 0x04 do not affect them.
- R7: When a sticky condition is high in the same cycle as a write that clears that bit, the bit stays set.
- R8: `irq_o` equals, one cycle later, the OR over all bits of status ANDed with mask.
- R9: Only the low 7 bits of the status and mask registers exist. Write-data bits 7 and above are ignored, and read-data bits 7 and above are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cond_i | input | 7 | Per-source condition lines from the transfer engine |
| addr_i | input | 6 | Register byte offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the unit with its default parameters: seven interrupt bits, bits 3 and 4 live and the rest sticky, and a 6-bit address. This covers every bit of both the sticky and the live variant, and all 64 offsets, including the unmapped ones. A behavioural model with a random phase drives conditions and writes together. That phase reaches the event-versus-clear collision, set and clear writes racing with events, and upper write-data bits set to ones.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int IRQ_W  = 7;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_STATUS = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_SET    = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_CLR    = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 6'h10;

  localparam int BIT_MODE_FAULT = 1;
  localparam int BIT_TX_LOW     = 2;
  localparam int BIT_TX_FULL    = 3;
  localparam int BIT_RX_AVAIL   = 4;

  // bits that mirror a level rather than latch an event
  localparam logic [IRQ_W-1:0] LIVE_DEFAULT =
    IRQ_W'((1 << BIT_TX_FULL) | (1 << BIT_RX_AVAIL));
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int               W    = 7,
  parameter logic [W-1:0]     LIVE = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic bit_q;
    if (LIVE[b]) begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) bit_q <= 1'b0;
        else         bit_q <= cond_i[b];
    end else begin : g_sticky
      // a new event beats a same-cycle clear
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) bit_q <= 1'b0;
        else         bit_q <= cond_i[b] | (bit_q & ~clr_i[b]);
    end
    assign status_o[b] = bit_q;
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= (mask_q | set_i) & ~clr_i;
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import spi_irq_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int W  = 7
) (
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  status_i,
  input  logic [W-1:0]  mask_i,
  output logic [DW-1:0] rdata_o
);
  localparam int PAD = DW - W;
  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(OFF_STATUS))    rdata_o = {{PAD{1'b0}}, status_i};
    else if (addr_i == AW'(OFF_MASK)) rdata_o = {{PAD{1'b0}}, mask_i};
  end
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int               IRQ_BITS  = IRQ_W,
  parameter int               AW        = ADDR_W,
  parameter int               DW        = DATA_W,
  parameter logic [IRQ_W-1:0] LIVE_BITS = LIVE_DEFAULT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IRQ_BITS-1:0] cond_i,
  input  logic [AW-1:0]       addr_i,
  input  logic                we_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic                irq_o
);
  logic [IRQ_BITS-1:0] wbits, st_clr, mk_set, mk_clr, status_q, mask_q;
  logic                irq_q;

  assign wbits  = wdata_i[IRQ_BITS-1:0];
  assign st_clr = (we_i && addr_i == AW'(OFF_STATUS)) ? wbits : '0;
  assign mk_set = (we_i && addr_i == AW'(OFF_SET))    ? wbits : '0;
  assign mk_clr = (we_i && addr_i == AW'(OFF_CLR))    ? wbits : '0;

  irq_status_bank #(.W(IRQ_BITS), .LIVE(LIVE_BITS[IRQ_BITS-1:0])) i_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(cond_i),
    .clr_i(st_clr), .status_o(status_q));

  irq_mask_bank #(.W(IRQ_BITS)) i_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(mk_set),
    .clr_i(mk_clr), .mask_o(mask_q));

  irq_read_mux #(.AW(AW), .DW(DW), .W(IRQ_BITS)) i_rmux (
    .addr_i(addr_i), .status_i(status_q), .mask_i(mask_q), .rdata_o(rdata_o));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_q & mask_q);

  assign irq_o = irq_q;
endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk
  import spi_irq_pkg::*;
#(
  parameter int               IRQ_BITS  = IRQ_W,
  parameter int               AW        = ADDR_W,
  parameter int               DW        = DATA_W,
  parameter logic [IRQ_W-1:0] LIVE_BITS = LIVE_DEFAULT
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [IRQ_BITS-1:0] cond_i,
  input logic [AW-1:0]       addr_i,
  input logic                we_i,
  input logic [DW-1:0]       wdata_i,
  input logic [DW-1:0]       rdata_o,
  input logic                irq_o,
  input logic [IRQ_BITS-1:0] status_q,
  input logic [IRQ_BITS-1:0] mask_q
);
  localparam logic [IRQ_BITS-1:0] LV = LIVE_BITS[IRQ_BITS-1:0];

  a_r2_set_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(OFF_SET)) |=>
      ((mask_q & $past(wdata_i[IRQ_BITS-1:0])) == $past(wdata_i[IRQ_BITS-1:0])));

  a_r3_clr_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(OFF_CLR)) |=>
      ((mask_q & $past(wdata_i[IRQ_BITS-1:0])) == '0));

  a_r4_wo_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(OFF_SET) || addr_i == AW'(OFF_CLR)) |-> (rdata_o == '0));

  a_r6_live_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & LV) == ($past(cond_i) & LV)));

  a_r7_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(cond_i & ~LV)) == $past(cond_i & ~LV)));

  a_r8_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == |($past(status_q & mask_q))));

  a_r9_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:IRQ_BITS] == '0);
endmodule

bind spi_irq_unit spi_irq_chk #(
  .IRQ_BITS(IRQ_BITS), .AW(AW), .DW(DW), .LIVE_BITS(LIVE_BITS)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(cond_i), .addr_i(addr_i),
  .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
  .status_q(status_q), .mask_q(mask_q));

// File: tb/test_spi_irq_unit.sv
module test_spi_irq_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0, irq;
  logic [6:0]  cond = '0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;

  int errors = 0, checks = 0;
  bit done = 0;

  // reference model state
  int m_status = 0, m_mask = 0, m_irq = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_irq_unit i_spi_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .cond_i(cond), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int model_read(input int a);
    if (a == 'h04) return m_status;
    if (a == 'h10) return m_mask;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_status <= 0; m_mask <= 0; m_irq <= 0;
    end else begin
      int clr, sticky, nmask, w;
      w      = int'(wdata[6:0]);
      clr    = (we && addr == 6'h04) ? w : 0;
      sticky = (m_status & ~clr & 'h67) | (int'(cond) & 'h67);
      m_status <= sticky | (int'(cond) & 'h18);
      nmask = m_mask;
      if (we && addr == 6'h08) nmask = nmask | w;
      if (we && addr == 6'h0C) nmask = nmask & ~w;
      m_mask <= nmask;
      m_irq  <= ((m_status & m_mask) != 0) ? 1 : 0;
    end
  end

  // compare every clock, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && !done) begin
      chk(int'(irq) == m_irq, "R8 irq vs model", int'(irq), m_irq);
      chk(int'(rdata) == model_read(int'(addr)), "R4 rdata vs model",
          int'(rdata), model_read(int'(addr)));
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input int exp, input string req);
    addr = a; #1;
    chk(int'(rdata) == exp, req, int'(rdata), exp);
  endtask

  initial begin
    #(CLK_P*200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk(6'h04, 0, "R1 status reset");
    rd_chk(6'h10, 0, "R1 mask reset");
    chk(irq == 1'b0, "R1 irq reset", int'(irq), 0);

    wr(6'h08, 32'hFFFF_FF7F);
    rd_chk(6'h10, 'h7F, "R2 set all, R9 upper ignored");
    wr(6'h0C, 32'h0000_0005);
    rd_chk(6'h10, 'h7A, "R3 clear bits 0 and 2");
    wr(6'h08, 32'h0000_0001);
    rd_chk(6'h10, 'h7B, "R2 set bit 0 only");
    rd_chk(6'h08, 0, "R4 set reg reads zero");
    rd_chk(6'h0C, 0, "R4 clear reg reads zero");
    rd_chk(6'h00, 0, "R4 unmapped 0x00");
    rd_chk(6'h14, 0, "R4 unmapped 0x14");

    // sticky mode fault pulse
    @(negedge clk); cond = 7'h02;
    @(negedge clk); cond = '0;
    rd_chk(6'h04, 'h02, "R5 mode fault latched");
    chk(irq == 1'b0, "R8 irq one cycle later", int'(irq), 0);
    @(negedge clk);
    chk(irq == 1'b1, "R8 irq raised", int'(irq), 1);
    wr(6'h04, 32'h0);
    rd_chk(6'h04, 'h02, "R5 write zero keeps bit");
    wr(6'h04, 32'h2);
    rd_chk(6'h04, 0, "R5 write one clears");
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq dropped", int'(irq), 0);

    // live bits
    @(negedge clk); cond = 7'h18;
    @(negedge clk);
    rd_chk(6'h04, 'h18, "R6 live bits follow");
    wr(6'h04, 32'h18);
    rd_chk(6'h04, 'h18, "R6 clear has no effect");
    cond = '0;
    @(negedge clk);
    rd_chk(6'h04, 0, "R6 live bits drop");

    // collision on bit 2
    @(negedge clk); cond = 7'h04; addr = 6'h04; wdata = 32'h4; we = 1'b1;
    @(negedge clk); cond = '0; we = 1'b0;
    rd_chk(6'h04, 'h04, "R7 event beats clear");
    wr(6'h04, 32'h4);

    // masked source raises no irq
    wr(6'h0C, 32'h7F);
    @(negedge clk); cond = 7'h40;
    @(negedge clk); cond = '0;
    repeat (2) @(negedge clk);
    rd_chk(6'h04, 'h40, "R5 bit 6 latched while masked");
    chk(irq == 1'b0, "R8 masked no irq", int'(irq), 0);
    wr(6'h04, 32'h7F);

    // random phase, model compares every cycle
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      cond  = 7'($urandom) & 7'($urandom);
      addr  = 6'($urandom);
      if ($urandom_range(0, 1) == 1) addr = 6'h04 + 6'(4 * $urandom_range(0, 3));
      wdata = $urandom;
      we    = ($urandom_range(0, 2) == 0);
    end
    @(negedge clk); we = 1'b0; cond = '0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule